// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block turns the bus clock of a serial communications interface into two timing strobes: a sample strobe at sixteen times the line rate, and a bit strobe at the line rate itself. The bus clock it counts is the CPU clock divided by four. All division comes from one byte-wide rate register. The division is a non-power-of-two prescale of 1, 3, 4 or 13, times a further power of two from 1 to 128, times the fixed oversampling factor of 16.

Software writes the rate register through a simple write strobe and reads it back on a parallel output. Each write restarts the counting chain, so the first strobes after a rate change come at a known distance from the write. The block also presents the bus cycles per bit as a number, for timers that must wait a whole character. A strap input picks the value loaded at reset. With the strap low the register clears. With the strap high the register loads a slow rate, as a bootstrap loader expects.

Top module: `sci_baud_gen`

## Requirements
- R1: While `rst` is high with `boot_mode` low, the rate register loads 0x00. After reset `rate_q` reads 0x00 and `bit_cycles` reads 16.
- R2: While `rst` is high with `boot_mode` high, the rate register loads 0x33 (prescale 13, power 8). After reset `bit_cycles` reads 1664.
- R3: Register bits 5:4 select the prescale ratio: code 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R4: Register bits 2:0 hold an exponent n that multiplies the division by 2^n, so the range is 1 to 128.
- R5: `tick_x16` is a one-cycle pulse. With no write, it fires in every P-th bus cycle, where P is the prescale ratio times 2^n. The first pulse comes in the P-th cycle after a restart.
- R6: `tick_bit` fires together with every sixteenth `tick_x16` pulse, and never at any other time. The first pulse comes in cycle 16·P after a restart.
- R7: `bit_cycles` equals 16·P for the value held in the register.
- R8: A cycle with `wr_en` high restarts both counter stages. No strobe fires in the write cycle itself, and the next strobes follow R5 and R6, counting from the cycle after the write.
- R9: `rate_q` reads back exactly the last byte written, including bits 7, 6 and 3.
- R10: Bits 7, 6 and 3 of the register are stored but have no effect on `tick_x16`, `tick_bit` or `bit_cycles`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock (CPU clock / 4) |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | Strap that selects the bootstrap reset value |
| wr_en | input | 1 | Write strobe for the rate register |
| wr_data | input | 8 | Byte written to the rate register |
| rate_q | output | 8 | Current contents of the rate register |
| tick_x16 | output | 1 | Oversampling strobe, sixteen per bit |
| tick_bit | output | 1 | Bit-rate strobe |
| bit_cycles | output | 15 | Bus cycles per bit for the current setting |

## Verification
A register write and a strobe can fall in the same cycle. The write then has to win: the strobe that was due is dropped, and the count starts again from the next cycle. The bench provokes this by placing a second write exactly on the cycle where an x16 strobe, and in another case a bit strobe, would have fired. The scoreboard then expects no strobe in that cycle, and the first new strobe a full period after it.

// File: rtl/sci_baud_pkg.sv
package sci_baud_pkg;

    localparam int REG_W      = 8;
    localparam int PRE_CODE_W = 2;
    localparam int EXP_W      = 3;
    localparam int PRE_W      = 4;                  // holds the largest ratio, 13
    localparam int POW_W      = (1 << EXP_W) - 1;   // holds 2^7 - 1
    localparam logic [REG_W-1:0] BOOT_VALUE = 8'h33;

    // Layout of the rate register; field positions are decoded below.
    typedef struct packed {
        logic                  test_clr;   // bit 7, stored only
        logic                  spare;      // bit 6, stored only
        logic [PRE_CODE_W-1:0] pre_code;   // bits 5:4
        logic                  test_chk;   // bit 3, stored only
        logic [EXP_W-1:0]      pow_exp;    // bits 2:0
    } rate_reg_t;

    function automatic logic [PRE_W-1:0] pre_ratio(input logic [PRE_CODE_W-1:0] code);
        case (code)
            2'b00:   return PRE_W'(1);
            2'b01:   return PRE_W'(3);
            2'b10:   return PRE_W'(4);
            default: return PRE_W'(13);
        endcase
    endfunction

endpackage

// File: rtl/sci_rate_reg.sv
module sci_rate_reg
    import sci_baud_pkg::*;
#(
    parameter int OVS_LOG2 = 4,
    parameter int CYC_W    = PRE_W + POW_W + OVS_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boot_mode,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output rate_reg_t        reg_q,
    output logic [PRE_W-1:0] pre_lim,
    output logic [POW_W-1:0] pow_lim,
    output logic [CYC_W-1:0] cycles_per_bit
);

    logic [PRE_W-1:0] ratio;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= boot_mode ? rate_reg_t'(BOOT_VALUE) : rate_reg_t'('0);
        end else if (wr_en) begin
            reg_q <= rate_reg_t'(wr_data);
        end
    end

    always_comb begin
        ratio          = pre_ratio(reg_q.pre_code);
        pre_lim        = ratio - PRE_W'(1);
        pow_lim        = (POW_W'(1) << reg_q.pow_exp) - POW_W'(1);
        cycles_per_bit = CYC_W'(ratio) << (int'(reg_q.pow_exp) + OVS_LOG2);
    end

    // reset-load check, needs the reset and strap of the previous cycle
    logic rst_d, boot_d;
    always_ff @(posedge clk) begin
        rst_d  <= rst;
        boot_d <= boot_mode;
        if (rst_d && !rst) begin
            AST_RESET_LOAD: assert (reg_q == (boot_d ? rate_reg_t'(BOOT_VALUE) : rate_reg_t'('0))); // R1 R2
        end
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(reg_q)); // R9

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> reg_q == $past(wr_data)); // R9

endmodule

// File: rtl/sci_prescaler.sv
module sci_prescaler
    import sci_baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_lim,
    input  logic [POW_W-1:0] pow_lim,
    output logic             tick_x16
);

    logic [PRE_W-1:0] pre_cnt;
    logic [POW_W-1:0] pow_cnt;
    logic             pre_wrap;

    assign pre_wrap = (pre_cnt == pre_lim);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
            pow_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            pow_cnt <= (pow_cnt == pow_lim) ? '0 : pow_cnt + POW_W'(1);
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    assign tick_x16 = !restart && pre_wrap && (pow_cnt == pow_lim);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (pre_cnt <= pre_lim) && (pow_cnt <= pow_lim)); // R5

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pre_cnt == '0) && (pow_cnt == '0)); // R8

endmodule

// File: rtl/sci_bit_div.sv
module sci_bit_div #(
    parameter int OVS_LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick_x16,
    output logic tick_bit
);

    localparam logic [OVS_LOG2-1:0] LAST = '1;

    logic [OVS_LOG2-1:0] os_cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            os_cnt <= '0;
        end else if (tick_x16) begin
            os_cnt <= os_cnt + OVS_LOG2'(1);
        end
    end

    assign tick_bit = tick_x16 && (os_cnt == LAST);

    AST_OS_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        tick_x16 |=> os_cnt == $past(os_cnt) + OVS_LOG2'(1)); // R6

    AST_OS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick_x16 && !restart) |=> $stable(os_cnt)); // R6

endmodule

// File: rtl/sci_baud_gen.sv
module sci_baud_gen
    import sci_baud_pkg::*;
#(
    parameter int OVS_LOG2 = 4,
    parameter int CYC_W    = PRE_W + POW_W + OVS_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boot_mode,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rate_q,
    output logic             tick_x16,
    output logic             tick_bit,
    output logic [CYC_W-1:0] bit_cycles
);

    rate_reg_t        reg_q;
    logic [PRE_W-1:0] pre_lim;
    logic [POW_W-1:0] pow_lim;

    sci_rate_reg #(.OVS_LOG2(OVS_LOG2), .CYC_W(CYC_W)) u_reg (
        .clk            (clk),
        .rst            (rst),
        .boot_mode      (boot_mode),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .reg_q          (reg_q),
        .pre_lim        (pre_lim),
        .pow_lim        (pow_lim),
        .cycles_per_bit (bit_cycles)
    );

    sci_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (wr_en),
        .pre_lim  (pre_lim),
        .pow_lim  (pow_lim),
        .tick_x16 (tick_x16)
    );

    sci_bit_div #(.OVS_LOG2(OVS_LOG2)) u_bit (
        .clk      (clk),
        .rst      (rst),
        .restart  (wr_en),
        .tick_x16 (tick_x16),
        .tick_bit (tick_bit)
    );

    assign rate_q = reg_q;

    AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !tick_x16 && !tick_bit); // R8

    AST_BIT_WITH_X16: assert property (@(posedge clk) disable iff (rst)
        tick_bit |-> tick_x16); // R6

endmodule

// File: tb/test_sci_baud_gen.sv
module test_sci_baud_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rate_q;
    logic        tick_x16;
    logic        tick_bit;
    logic [14:0] bit_cycles;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];      // scoreboard: values the driver has written

    always #10 clk = ~clk;     // 50 MHz

    sci_baud_gen i_sci_baud_gen (
        .clk(clk), .rst(rst), .boot_mode(boot_mode), .wr_en(wr_en),
        .wr_data(wr_data), .rate_q(rate_q), .tick_x16(tick_x16),
        .tick_bit(tick_bit), .bit_cycles(bit_cycles)
    );

    // R3 R4 R10: period of the x16 strobe from the register value
    function automatic int period_of(input logic [7:0] v);
        int r;
        case (v[5:4])
            2'b00: r = 1;
            2'b01: r = 3;
            2'b10: r = 4;
            default: r = 13;
        endcase
        return r << v[2:0];
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        exp_q.push_back(v);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_data = v;
        @(posedge clk); #2;
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // monitor: compares the strobes with the model on every cycle
    initial begin
        logic [7:0] cur;
        int cyc;
        int p;
        cur = 8'h00;
        cyc = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                cur = boot_mode ? 8'h33 : 8'h00;
                cyc = 0;
            end else if (wr_en) begin
                if (exp_q.size() == 0) begin
                    check("R8 unexpected write", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                end
                check("R8 no x16 tick in write cycle", int'(tick_x16), 0);
                check("R8 no bit tick in write cycle", int'(tick_bit), 0);
                cyc = 0;
            end else begin
                cyc++;
                p = period_of(cur);
                if (cyc == 1) begin
                    check("R1 R2 R9 readback", int'(rate_q), int'(cur));
                    check("R7 R10 bit_cycles", int'(bit_cycles), 16 * p);
                end
                if (tick_x16 || (cyc % p == 0))
                    check("R5 R3 R4 x16 tick", int'(tick_x16), int'(cyc % p == 0));
                if (tick_bit || (cyc % (16 * p) == 0))
                    check("R6 bit tick", int'(tick_bit), int'(cyc % (16 * p) == 0));
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: plain reset
        boot_mode = 1'b0;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(40);

        write_reg(8'h10);  idle(100);   // R3 ratio 3
        write_reg(8'h21);  idle(200);   // R3 R4 ratio 4, x2
        // R8: second write lands on the cycle of the first x16 tick (P=8)
        write_reg(8'h21);  idle(6);
        write_reg(8'h21);  idle(200);
        // R8: write lands on the cycle of the first bit tick (P=1, 16 cycles)
        write_reg(8'h00);  idle(14);
        write_reg(8'h00);  idle(40);
        write_reg(8'h22);  idle(300);   // R4 ratio 4, x4
        write_reg(8'h30);  idle(250);   // R3 ratio 13
        write_reg(8'hBB);  idle(1700);  // R9 R10 test bits with 13 x8
        write_reg(8'hC9);  idle(60);    // R9 R10 bits 7,6,3 with ratio 1, x2
        write_reg(8'h37);  idle(26700); // R4 slowest rate, 13 x128
        // R8: mid-period rewrite restarts the count
        write_reg(8'h13);  idle(17);
        write_reg(8'h13);  idle(400);

        // R2: bootstrap reset
        boot_mode = 1'b1;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        boot_mode = 1'b0;
        idle(1700);

        check("R8 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule